// File: doc/BRIEF.md
# NOR Flash Write-Buffer Program Sequencer

This block drives a burst of consecutive 16-bit words into a NOR flash through the flash's write-buffer command. A single-cycle `start` strobe supplies a start word address and a word count. The sequencer then runs through a fixed series of bus writes. First come two unlock writes. Next come a buffer-load command and a count word, then one write for each data word. The series ends with a confirm command. Each bus write goes through a simple write-cycle port. The port holds a request with its address and data until the downstream bus controller acknowledges it.

Data words arrive on a valid/ready stream. `s_ready` is high only while the sequencer is in its data phase and no bus write is outstanding. A word is taken on a clock edge where `s_valid` and `s_ready` are both high. The producer may drop `s_valid` at any time: the sequencer waits and issues nothing. After taking a word, the sequencer holds `s_ready` low until the flash write for that word is acknowledged. The producer must hold `s_data` stable while `s_valid` is high and the word has not been taken.

When the confirm write is acknowledged, `done` pulses for one clock and the block returns to idle. A start strobe that arrives while a burst is in progress is refused. A start with a word count of zero is rejected and causes no bus activity.

Top module: `nor_wbuf_prog`

## Requirements
- R1: The first two bus writes of a burst are data 0x00AA to word address 0x555, then data 0x0055 to word address 0x2AA.
- R2: The third bus write carries data 0x0025 to the burst's start address.
- R3: The fourth bus write goes to the start address and carries the word count minus one, zero-extended to 16 bits.
- R4: For a count N, the next N bus writes carry the streamed words in arrival order, to addresses start, start+1, ..., start+N-1. Address arithmetic wraps modulo 2^ADDR_W.
- R5: The last bus write carries data 0x0029 to the address of the last loaded data word. `done` is high for exactly the one cycle after that write's acknowledge, and `busy` is low from that cycle on.
- R6: A `start` while `busy` is high is refused. `refused` is high in the following cycle, and the ongoing burst continues with its original address and count.
- R7: A `start` with `word_count` = 0 while idle sets `err_zero` in the following cycle. No bus write is issued, and `busy` stays low.
- R8: While the stream has no valid word, the sequencer stays in its data phase and issues no bus write. `s_ready` is high only in the data phase with no write outstanding.
- R9: `wr_req` stays high, with `wr_addr` and `wr_data` stable, until `wr_ack` is sampled high. Each such handshake completes exactly one write.
- R10: After reset, `busy`, `wr_req`, `s_ready`, `done`, `refused` and `err_zero` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request strobe |
| start_addr | input | ADDR_W | First word address of the burst |
| word_count | input | CNT_W | Number of data words (0 is rejected) |
| busy | output | 1 | A burst is in progress |
| refused | output | 1 | One-cycle pulse: start arrived while busy |
| err_zero | output | 1 | One-cycle pulse: start with a zero count |
| done | output | 1 | One-cycle pulse after the confirm write completes |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Sequencer takes a stream word |
| s_data | input | DATA_W | Stream data word |
| wr_req | output | 1 | Flash write cycle requested |
| wr_addr | output | ADDR_W | Word address of the write cycle |
| wr_data | output | DATA_W | Data of the write cycle |
| wr_ack | input | 1 | Write cycle accepted by the bus |

## Verification
Two situations are hard to reach: a refused start, which needs a second strobe landing while the unlock writes are still pending, and a stalled stream in the data phase. The bench reaches the first by strobing `start` again one cycle after a burst begins. The acknowledge responder gives the pending unlock writes a few cycles of delay, so that strobe lands mid-burst. For the stall, the stream driver withholds one word for ten cycles, which is longer than the longest acknowledge delay. During that window the bench checks that no write is outstanding. A burst that starts near the top of the address space checks that the data addresses and the confirm address wrap.

// File: rtl/nor_wbuf_pkg.sv
package nor_wbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UNLK1 = 3'd1,
    ST_UNLK2 = 3'd2,
    ST_LOAD  = 3'd3,
    ST_COUNT = 3'd4,
    ST_DATA  = 3'd5,
    ST_CONF  = 3'd6
  } seq_state_t;

  localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLK_B = 8'h55;
  localparam logic [7:0]  CMD_LOAD   = 8'h25;
  localparam logic [7:0]  CMD_CONF   = 8'h29;
  localparam logic [11:0] ADR_UNLK_A = 12'h555;
  localparam logic [11:0] ADR_UNLK_B = 12'h2AA;
endpackage

// File: rtl/nor_wbuf_port.sv
module nor_wbuf_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cyc_done
);
  assign cyc_done = wr_req && wr_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (cyc_done) begin
      wr_req <= 1'b0;
    end else if (issue && !wr_req) begin
      wr_req  <= 1'b1;
      wr_addr <= addr_in;
      wr_data <= data_in;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R9

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> !wr_req); // R9
endmodule

// File: rtl/nor_wbuf_track.sv
module nor_wbuf_track #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              word_take,
  input  logic              word_done,
  input  logic              in_data,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] last_addr,
  output logic [CNT_W-1:0]  cnt_m1,
  output logic              last_word
);
  logic [CNT_W-1:0] remain;

  assign last_word = (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      last_addr <= '0;
      cnt_m1    <= '0;
      remain    <= '0;
    end else if (load) begin
      base_addr <= start_addr;
      cur_addr  <= start_addr;
      last_addr <= start_addr;
      cnt_m1    <= word_count - CNT_W'(1);
      remain    <= word_count;
    end else begin
      if (word_take) last_addr <= cur_addr;
      if (word_done) begin
        cur_addr <= cur_addr + ADDR_W'(1);
        remain   <= remain - CNT_W'(1);
      end
    end
  end

  AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> remain != '0); // R4
endmodule

// File: rtl/nor_wbuf_fsm.sv
module nor_wbuf_fsm
  import nor_wbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       count_zero,
  input  logic       s_valid,
  input  logic       cyc_done,
  input  logic       last_word,
  output seq_state_t state,
  output logic       issue,
  output logic       load,
  output logic       s_ready,
  output logic       busy,
  output logic       done,
  output logic       refused,
  output logic       err_zero
);
  logic inflight;
  logic is_cmd;

  assign busy    = (state != ST_IDLE);
  assign load    = start && !busy && !count_zero;
  assign s_ready = (state == ST_DATA) && !inflight;
  assign is_cmd  = busy && (state != ST_DATA);
  assign issue   = !inflight && (is_cmd || (s_ready && s_valid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      inflight <= 1'b0;
      done     <= 1'b0;
      refused  <= 1'b0;
      err_zero <= 1'b0;
    end else begin
      done     <= 1'b0;
      refused  <= start && busy;
      err_zero <= start && !busy && count_zero;
      if (issue) inflight <= 1'b1;
      if (cyc_done) inflight <= 1'b0;
      unique case (state)
        ST_IDLE:  if (load) state <= ST_UNLK1;
        ST_UNLK1: if (cyc_done) state <= ST_UNLK2;
        ST_UNLK2: if (cyc_done) state <= ST_LOAD;
        ST_LOAD:  if (cyc_done) state <= ST_COUNT;
        ST_COUNT: if (cyc_done) state <= ST_DATA;
        ST_DATA:  if (cyc_done && last_word) state <= ST_CONF;
        ST_CONF:  if (cyc_done) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5

  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> refused && busy); // R6

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && count_zero |=> err_zero && !busy); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && !s_valid |=> state == ST_DATA && s_ready); // R8

  AST_CYCLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> inflight && busy); // R9
endmodule

// File: rtl/nor_wbuf_prog.sv
module nor_wbuf_prog
  import nor_wbuf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              refused,
  output logic              err_zero,
  output logic              done,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack
);
  seq_state_t        state;
  logic              issue, load, cyc_done, last_word;
  logic [ADDR_W-1:0] base_addr, cur_addr, last_addr, nxt_addr;
  logic [CNT_W-1:0]  cnt_m1;
  logic [DATA_W-1:0] nxt_data;
  logic              in_data;

  assign in_data = (state == ST_DATA);

  nor_wbuf_fsm u_fsm (
    .clk, .rst_n, .start,
    .count_zero (word_count == '0),
    .s_valid, .cyc_done, .last_word,
    .state, .issue, .load, .s_ready, .busy, .done, .refused, .err_zero
  );

  nor_wbuf_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk, .rst_n, .load, .start_addr, .word_count,
    .word_take (issue && in_data),
    .word_done (cyc_done && in_data),
    .in_data,
    .base_addr, .cur_addr, .last_addr, .cnt_m1, .last_word
  );

  always_comb begin
    nxt_addr = base_addr;
    nxt_data = '0;
    unique case (state)
      ST_UNLK1: begin nxt_addr = ADDR_W'(ADR_UNLK_A); nxt_data = DATA_W'(CMD_UNLK_A); end
      ST_UNLK2: begin nxt_addr = ADDR_W'(ADR_UNLK_B); nxt_data = DATA_W'(CMD_UNLK_B); end
      ST_LOAD:  begin nxt_addr = base_addr;           nxt_data = DATA_W'(CMD_LOAD);   end
      ST_COUNT: begin nxt_addr = base_addr;           nxt_data = DATA_W'(cnt_m1);     end
      ST_DATA:  begin nxt_addr = cur_addr;            nxt_data = s_data;              end
      ST_CONF:  begin nxt_addr = last_addr;           nxt_data = DATA_W'(CMD_CONF);   end
      default:  begin nxt_addr = base_addr;           nxt_data = '0;                  end
    endcase
  end

  nor_wbuf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk, .rst_n, .issue,
    .addr_in (nxt_addr),
    .data_in (nxt_data),
    .wr_ack, .wr_req, .wr_addr, .wr_data, .cyc_done
  );

  AST_READY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !wr_req); // R8

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_req && !s_ready); // R7
endmodule

// File: tb/tb_nor_wbuf_prog.sv
`timescale 1ns/1ps
module tb_nor_wbuf_prog;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  word_count = '0;
  logic busy, refused, err_zero, done, s_ready, wr_req;
  logic s_valid = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic wr_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [ADDR_W+DATA_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  nor_wbuf_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk, .rst_n, .start, .start_addr, .word_count, .busy, .refused,
    .err_zero, .done, .s_valid, .s_ready, .s_data, .wr_req, .wr_addr,
    .wr_data, .wr_ack
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor and acknowledge responder: compares every completed write with the scoreboard
  initial begin
    bit holding = 0;
    int wait_c = 0;
    int dsel = 0;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic [ADDR_W+DATA_W-1:0] e;
    forever begin
      @(negedge clk);
      if (wr_ack) begin
        wr_ack = 1'b0;
      end else if (wr_req) begin
        if (!holding) begin
          holding = 1; h_addr = wr_addr; h_data = wr_data;
          wait_c = dsel; dsel = (dsel + 1) % 4;
        end else begin
          check(wr_addr == h_addr && wr_data == h_data, "R9 stable request",
                {wr_addr, wr_data}, {h_addr, h_data});
        end
        if (wait_c == 0) begin
          if (exp_q.size() == 0) begin
            check(0, "R7/R9 unexpected write", {wr_addr, wr_data}, 0);
          end else begin
            e = exp_q.pop_front();
            check({wr_addr, wr_data} == e, "R1-sequence write (R1 R2 R3 R4 R5)",
                  {wr_addr, wr_data}, e);
          end
          wr_ack = 1'b1; holding = 0;
        end else begin
          wait_c--;
        end
      end
    end
  end

  task automatic push(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic burst(input logic [ADDR_W-1:0] a, input int n, input int gap,
                       input bit do_refuse, input int stall_at);
    logic [ADDR_W-1:0] last;
    push(24'h000555, 16'h00AA);            // R1
    push(24'h0002AA, 16'h0055);            // R1
    push(a, 16'h0025);                     // R2
    push(a, DATA_W'(n - 1));               // R3
    for (int i = 0; i < n; i++) push(a + ADDR_W'(i), 16'hC000 ^ DATA_W'(i * 37)); // R4
    last = a + ADDR_W'(n - 1);
    push(last, 16'h0029);                  // R5
    start = 1; start_addr = a; word_count = CNT_W'(n);
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    if (do_refuse) begin
      start = 1; start_addr = 24'h777777; word_count = 6'd9;
      @(negedge clk);
      start = 0;
      check(refused == 1'b1, "R6 refused pulse", refused, 1);
    end
    for (int i = 0; i < n; i++) begin
      s_valid = 0;
      repeat (gap) @(negedge clk);
      if (i == stall_at) begin
        repeat (10) @(negedge clk);
        check(wr_req == 1'b0, "R8 no write while stalled", wr_req, 0);
        check(busy == 1'b1 && s_ready == 1'b1, "R8 waiting in data phase",
              {busy, s_ready}, 2'b11);
      end
      s_valid = 1; s_data = 16'hC000 ^ DATA_W'(i * 37);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 0;
    begin
      int g = 0;
      while (!done && g < 400) begin @(negedge clk); g++; end
    end
    check(done == 1'b1, "R5 done seen", done, 1);
    check(busy == 1'b0, "R5 idle with done", busy, 0);
    check(exp_q.size() == 0, "R5 all writes done", exp_q.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, wr_req, s_ready, done, refused, err_zero} == 6'b0, "R10 reset state",
          {busy, wr_req, s_ready, done, refused, err_zero}, 0);
    rst_n = 1;
    @(negedge clk);
    check({busy, wr_req, s_ready} == 3'b0, "R10 idle after reset", {busy, wr_req, s_ready}, 0);

    // R7: zero count
    start = 1; start_addr = 24'h001234; word_count = '0;
    @(negedge clk);
    start = 0;
    check(err_zero == 1'b1, "R7 err_zero pulse", err_zero, 1);
    check(busy == 1'b0, "R7 stays idle", busy, 0);
    repeat (5) begin
      @(negedge clk);
      check(wr_req == 1'b0 && busy == 1'b0, "R7 no bus cycle", {wr_req, busy}, 0);
    end

    burst(24'h001000, 1, 0, 0, -1);       // R1 R2 R3 R4 R5 single word
    burst(24'h002345, 5, 2, 1, 2);        // R6 refusal, R8 stall
    burst(24'hFFFFFE, 4, 0, 0, -1);       // R4 address wrap, R5 confirm to 000001
    burst(24'h0A0000, 32, 1, 0, -1);      // R4 long burst
    burst(24'h000040, 63, 0, 1, 10);      // R3 maximum count

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule